// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Pin Interrupts

This block is a general-purpose I/O port of up to 31 pins behind a small 32-bit register bus. The output latch of each pin changes only through two write-only strobe registers: one raises the latch bits written as 1, the other lowers them. A direction register decides which pins drive their pads. The sense of that register can be flipped at build time, so a 1 means input instead of output. Every pin input passes through a synchroniser, and the synchronised levels can be read back at any time.

Each pin can also raise an interrupt. A per-pin type bit picks between level and edge sensitivity, and a per-pin polarity bit picks the active level or edge. Edge events are held in a sticky pending bit until software clears it by writing 1. Level events are reported live. Pending pins that are both enabled and unmasked are ORed into one interrupt line. Software that needs both edges flips the polarity bit after each event.

Top module: `gio_ctrl`

## Requirements
- R1: After reset, every output latch is 0, every pin is an input (pad enable 0), the interrupt line is low, and every readable register reads 0. The one exception is the direction register when its sense is inverted, which reads all ones.
- R2: A write to byte offset 0x0C sets the latch of each pin whose data bit is 1, and a write to offset 0x10 clears it. Zero bits change nothing, the new latch value appears on the pins one clock after the write, and both offsets read as 0.
- R3: The direction register is at offset 0x00 and reads back what was written. With the normal sense, pad enable equals the register. With the inverted sense, pad enable is its complement. The pads follow one clock after the write.
- R4: A read returns its data, together with a one-cycle valid pulse, on the clock after the request. The input register at offset 0x04 shows a pin change on the second clock edge after that change reaches the pin.
- R5: For a pin whose type bit (offset 0x18) is 0, a synchronised 0-to-1 change sets its pending bit (offset 0x20) when its polarity bit (offset 0x1C) is 1. A 1-to-0 change sets it when the polarity bit is 0. A change in the other direction does not set it.
- R6: An edge pending bit stays set until a write of 1 to that bit of the pending register. Writing 0 leaves it set.
- R7: For a pin whose type bit is 1, the pending bit is 1 exactly while the synchronised level equals the polarity bit. Writes to the pending register do not affect it.
- R8: The interrupt line is high exactly when some pin has its pending bit, its enable bit (offset 0x14) and its mask bit (offset 0x24) all at 1. A mask bit of 0 hides the pin from the line, but its pending bit stays visible.
- R9: While a pin's enable bit is 0, no edge or level on that pin sets its pending bit.
- R10: If an edge is detected in the same cycle as a clearing write to that pin's pending bit, the bit ends up set.
- R11: Bits at or above the pin count read as 0 and ignore writes. Unassigned offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Output latch to the pads |
| pin_oe | output | NPINS | Pad drive enable, 1 drives the pad |
| irq | output | 1 | Combined interrupt |

## Verification
The case that matters most is a new edge on a pin arriving in the same cycle as a software write that clears that pin's pending bit. The bench moves the pin, counts the two synchroniser edges, and issues the clearing write so that it is sampled on the very edge where the edge detector fires. A correct design must still report the bit as pending when the register is read back. A plain clear with no competing edge is also checked, to show that the write itself works.

// File: rtl/gio_pkg.sv
package gio_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned WORD_W = ADDR_W - 2;

   // register slots, indexed by byte offset divided by four
   localparam logic [WORD_W-1:0] SLOT_DIR  = 6'h00;
   localparam logic [WORD_W-1:0] SLOT_LVL  = 6'h01;
   localparam logic [WORD_W-1:0] SLOT_SET  = 6'h03;
   localparam logic [WORD_W-1:0] SLOT_CLR  = 6'h04;
   localparam logic [WORD_W-1:0] SLOT_IEN  = 6'h05;
   localparam logic [WORD_W-1:0] SLOT_ITYP = 6'h06;
   localparam logic [WORD_W-1:0] SLOT_IPOL = 6'h07;
   localparam logic [WORD_W-1:0] SLOT_IPND = 6'h08;
   localparam logic [WORD_W-1:0] SLOT_IMSK = 6'h09;

endpackage

// File: rtl/gio_sync.sv
module gio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   // one more sample kept for edge comparison
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= '0;
      else        q_prev <= stage_q[STAGES-1];
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gio_pin_irq.sv
module gio_pin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic lvl_prev,
   input  logic en,
   input  logic typ,
   input  logic pol,
   input  logic clr,
   output logic pend
);

   logic edge_hit;
   logic level_hit;
   logic sticky_q;

   assign edge_hit  = pol ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);
   assign level_hit = (lvl == pol);

   // a new event beats a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sticky_q <= 1'b0;
      else if (typ)             sticky_q <= 1'b0;
      else if (en && edge_hit)  sticky_q <= 1'b1;
      else if (clr)             sticky_q <= 1'b0;
   end

   assign pend = typ ? (en & level_hit) : sticky_q;

endmodule

// File: rtl/gio_ctrl.sv
module gio_ctrl
   import gio_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter bit          OE_INVERT   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);

   localparam logic [NPINS-1:0] DIR_RST = OE_INVERT ? {NPINS{1'b1}} : {NPINS{1'b0}};

   generate
      if (NPINS < 1 || NPINS > 31) begin : g_bad_pins
         $error("gio_ctrl: NPINS must lie in 1..31");
      end
   endgenerate

   logic [WORD_W-1:0] slot;
   logic              wr_en;
   logic [NPINS-1:0]  wr_bits;
   logic              spare_unused;

   assign slot         = bus_addr[ADDR_W-1:2];
   assign wr_en        = bus_req & bus_we;
   assign wr_bits      = bus_wdata[NPINS-1:0];
   assign spare_unused = ^{bus_addr[1:0], bus_wdata};

   logic [NPINS-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imsk_q;
   logic [NPINS-1:0] lvl, lvl_prev, pend, clr_bits;

   // ---------------- control registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RST;
         out_q  <= '0;
         ien_q  <= '0;
         ityp_q <= '0;
         ipol_q <= '0;
         imsk_q <= '0;
      end else if (wr_en) begin
         case (slot)
            SLOT_DIR:  dir_q  <= wr_bits;
            SLOT_SET:  out_q  <= out_q | wr_bits;
            SLOT_CLR:  out_q  <= out_q & ~wr_bits;
            SLOT_IEN:  ien_q  <= wr_bits;
            SLOT_ITYP: ityp_q <= wr_bits;
            SLOT_IPOL: ipol_q <= wr_bits;
            SLOT_IMSK: imsk_q <= wr_bits;
            default: ;
         endcase
      end
   end

   assign clr_bits = (wr_en && slot == SLOT_IPND) ? wr_bits : '0;

   // ---------------- input synchroniser ----------------
   gio_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pin_in),
      .q      (lvl),
      .q_prev (lvl_prev)
   );

   // ---------------- per-pin interrupt slices ----------------
   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         gio_pin_irq u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[p]),
            .lvl_prev (lvl_prev[p]),
            .en       (ien_q[p]),
            .typ      (ityp_q[p]),
            .pol      (ipol_q[p]),
            .clr      (clr_bits[p]),
            .pend     (pend[p])
         );
      end
   endgenerate

   assign irq = |(pend & ien_q & imsk_q);

   // ---------------- pads ----------------
   assign pin_out = out_q;

   generate
      if (OE_INVERT) begin : g_oe_inv
         assign pin_oe = ~dir_q;
      end else begin : g_oe_norm
         assign pin_oe = dir_q;
      end
   endgenerate

   // ---------------- read path ----------------
   logic [BUS_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      case (slot)
         SLOT_DIR:  rd_word[NPINS-1:0] = dir_q;
         SLOT_LVL:  rd_word[NPINS-1:0] = lvl;
         SLOT_IEN:  rd_word[NPINS-1:0] = ien_q;
         SLOT_ITYP: rd_word[NPINS-1:0] = ityp_q;
         SLOT_IPOL: rd_word[NPINS-1:0] = ipol_q;
         SLOT_IPND: rd_word[NPINS-1:0] = pend;
         SLOT_IMSK: rd_word[NPINS-1:0] = imsk_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_req & ~bus_we;
         if (bus_req && !bus_we) bus_rdata <= rd_word;
      end
   end

endmodule

// File: rtl/gio_ctrl_chk.sv
module gio_ctrl_chk
   import gio_pkg::*;
#(
   parameter int unsigned NPINS     = 8,
   parameter bit          OE_INVERT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [7:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_rvalid,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq
);

   logic [WORD_W-1:0] slot;
   logic [NPINS-1:0]  wbits;
   logic              spare_unused;

   assign slot         = bus_addr[ADDR_W-1:2];
   assign wbits        = bus_wdata[NPINS-1:0];
   assign spare_unused = ^{bus_addr[1:0], bus_wdata};

   // R1: held in reset, no interrupt and no driven latch bits
   always @(posedge clk) begin
      if (!rst_n) begin
         p_quiet_in_reset_r1: assert (!irq && pin_out == '0);
      end
   end

   // R2: set strobe raises every written bit
   p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && slot == SLOT_SET)
      |=> ((pin_out & $past(wbits)) == $past(wbits)));

   // R2: clear strobe lowers every written bit
   p_clr_lowers_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && slot == SLOT_CLR)
      |=> ((pin_out & $past(wbits)) == '0));

   // R2: the latch moves only on a write
   p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_we) |=> $stable(pin_out));

   // R3: pad enable follows a direction write with the configured sense
   p_dir_pads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && slot == SLOT_DIR)
      |=> (pin_oe == (OE_INVERT ? ~$past(wbits) : $past(wbits))));

   // R4: a read is answered on the next clock
   p_read_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);

   // R4: no valid pulse without a read
   p_no_stray_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);

   // R11: bits above the pin count are always zero on a read
   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> (bus_rdata[31:NPINS] == '0));

endmodule

bind gio_ctrl gio_ctrl_chk #(
   .NPINS     (NPINS),
   .OE_INVERT (OE_INVERT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq        (irq)
);

// File: tb/sim_gio_ctrl.sv
module sim_gio_ctrl;

   localparam int unsigned N = 8;

   localparam logic [7:0] O_DIR  = 8'h00;
   localparam logic [7:0] O_LVL  = 8'h04;
   localparam logic [7:0] O_GAP  = 8'h08;
   localparam logic [7:0] O_SET  = 8'h0C;
   localparam logic [7:0] O_CLR  = 8'h10;
   localparam logic [7:0] O_IEN  = 8'h14;
   localparam logic [7:0] O_ITYP = 8'h18;
   localparam logic [7:0] O_IPOL = 8'h1C;
   localparam logic [7:0] O_IPND = 8'h20;
   localparam logic [7:0] O_IMSK = 8'h24;
   localparam logic [7:0] O_NONE = 8'h28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [N-1:0]  pin_in = '0;

   logic [31:0]   rdata0, rdata1;
   logic          rvalid0, rvalid1;
   logic [N-1:0]  pout0, pout1, poe0, poe1;
   logic          irq0, irq1;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gio_ctrl #(.NPINS(N), .OE_INVERT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
      .bus_rvalid(rvalid0), .pin_in(pin_in), .pin_out(pout0),
      .pin_oe(poe0), .irq(irq0));

   gio_ctrl #(.NPINS(N), .OE_INVERT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .bus_rvalid(rvalid1), .pin_in(pin_in), .pin_out(pout1),
      .pin_oe(poe1), .irq(irq1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_req = 1'b0;
      d = rdata0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic move_pins(input logic [N-1:0] v);
      @(negedge clk);
      pin_in = v;
      settle();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pin_out", {24'h0, pout0}, 32'h0);
      chk("R1 pin_oe normal", {24'h0, poe0}, 32'h0);
      chk("R1 pin_oe inverted", {24'h0, poe1}, 32'h0);
      chk("R1 irq", {31'h0, irq0}, 32'h0);
      bus_rd(O_DIR, d);
      chk("R1 dir normal", d, 32'h0);
      chk("R1 dir inverted", rdata1, 32'h0000_00FF);
      bus_rd(O_IPND, d);
      chk("R1 pending", d, 32'h0);
      bus_rd(O_IEN, d);
      chk("R1 enable", d, 32'h0);
   endtask

   task automatic t_outputs();
      logic [31:0] d;
      bus_wr(O_SET, 32'h0000_00A5);
      chk("R2 set", {24'h0, pout0}, 32'hA5);
      bus_wr(O_SET, 32'h0);
      chk("R2 zero set", {24'h0, pout0}, 32'hA5);
      bus_wr(O_CLR, 32'h0000_0005);
      chk("R2 clear", {24'h0, pout0}, 32'hA0);
      bus_wr(O_CLR, 32'h0);
      chk("R2 zero clear", {24'h0, pout0}, 32'hA0);
      bus_rd(O_SET, d);
      chk("R2 set reads 0", d, 32'h0);
      bus_rd(O_CLR, d);
      chk("R2 clear reads 0", d, 32'h0);
   endtask

   task automatic t_dir();
      logic [31:0] d;
      bus_wr(O_DIR, 32'h0000_003C);
      chk("R3 oe normal", {24'h0, poe0}, 32'h3C);
      chk("R3 oe inverted", {24'h0, poe1}, 32'hC3);
      bus_rd(O_DIR, d);
      chk("R3 dir readback", d, 32'h3C);
      chk("R3 dir readback inverted", rdata1, 32'h3C);
   endtask

   task automatic t_input();
      logic [31:0] d;
      @(negedge clk);
      pin_in = 8'h5A;
      bus_rd(O_LVL, d);
      chk("R4 input one edge after change", d, 32'h00);
      chk("R4 valid pulse", {31'h0, rvalid0}, 32'h1);
      bus_rd(O_LVL, d);
      chk("R4 input two edges after change", d, 32'h5A);
      @(negedge clk);
      chk("R4 valid drops", {31'h0, rvalid0}, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bus_wr(O_IMSK, 32'hFF);
      bus_wr(O_ITYP, 32'h00);
      bus_wr(O_IPOL, 32'h01);   // pin0 rising, others falling
      bus_wr(O_IEN,  32'hFF);
      move_pins(8'h02);
      bus_rd(O_IPND, d);
      chk("R5 falling edges on pins 3,4,6", d, 32'h58);
      bus_wr(O_IPND, 32'hFF);
      move_pins(8'h01);
      bus_rd(O_IPND, d);
      chk("R5 rise pin0 fall pin1", d, 32'h03);
      chk("R8 irq on pending", {31'h0, irq0}, 32'h1);
      bus_wr(O_IPND, 32'h00);
      bus_rd(O_IPND, d);
      chk("R6 zero write keeps", d, 32'h03);
      bus_wr(O_IPND, 32'h01);
      bus_rd(O_IPND, d);
      chk("R6 clear pin0 only", d, 32'h02);
      bus_wr(O_IPND, 32'h02);
      bus_rd(O_IPND, d);
      chk("R6 all cleared", d, 32'h00);
      chk("R8 irq drops", {31'h0, irq0}, 32'h0);
      move_pins(8'h02);
      bus_rd(O_IPND, d);
      chk("R5 opposite edges ignored", d, 32'h00);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      move_pins(8'h03);
      bus_rd(O_IPND, d);
      chk("R8 pending pin0", d, 32'h01);
      chk("R8 irq unmasked", {31'h0, irq0}, 32'h1);
      bus_wr(O_IMSK, 32'hFE);
      chk("R8 irq masked", {31'h0, irq0}, 32'h0);
      bus_rd(O_IPND, d);
      chk("R8 pending visible while masked", d, 32'h01);
      bus_wr(O_IMSK, 32'hFF);
      chk("R8 irq unmasked again", {31'h0, irq0}, 32'h1);
      bus_wr(O_IPND, 32'h01);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      bus_wr(O_IEN, 32'hFE);
      move_pins(8'h02);
      move_pins(8'h03);
      bus_rd(O_IPND, d);
      chk("R9 disabled pin not captured", d, 32'h00);
      chk("R9 irq low", {31'h0, irq0}, 32'h0);
      bus_wr(O_IEN, 32'hFF);
      bus_rd(O_IPND, d);
      chk("R9 nothing latched while disabled", d, 32'h00);
   endtask

   task automatic t_level();
      logic [31:0] d;
      bus_wr(O_ITYP, 32'h0C);
      bus_wr(O_IPOL, 32'h05);   // pin2 level high, pin3 level low
      bus_rd(O_IPND, d);
      chk("R7 pin3 low active", d, 32'h08);
      chk("R7 irq level", {31'h0, irq0}, 32'h1);
      move_pins(8'h0F);
      bus_rd(O_IPND, d);
      chk("R7 pin2 high active", d, 32'h04);
      bus_wr(O_IPND, 32'h0C);
      bus_rd(O_IPND, d);
      chk("R7 clear ignored", d, 32'h04);
      bus_wr(O_ITYP, 32'h00);
      bus_rd(O_IPND, d);
      chk("R7 back to edge clean", d, 32'h00);
      chk("R7 irq low", {31'h0, irq0}, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      bus_wr(O_IPOL, 32'h01);
      move_pins(8'h0E);
      move_pins(8'h0F);
      bus_rd(O_IPND, d);
      chk("R10 first edge", d, 32'h01);
      move_pins(8'h0E);
      @(negedge clk);
      pin_in = 8'h0F;
      @(posedge clk);
      @(posedge clk);
      bus_wr(O_IPND, 32'h01);   // sampled on the detecting edge
      bus_rd(O_IPND, d);
      chk("R10 edge beats clear", d, 32'h01);
      bus_wr(O_IPND, 32'h01);
      bus_rd(O_IPND, d);
      chk("R10 plain clear", d, 32'h00);
   endtask

   task automatic t_upper();
      logic [31:0] d;
      bus_wr(O_DIR, 32'hFFFF_FFFF);
      bus_rd(O_DIR, d);
      chk("R11 upper dir bits zero", d, 32'h0000_00FF);
      chk("R11 inverted oe", {24'h0, poe1}, 32'h00);
      bus_rd(O_NONE, d);
      chk("R11 unassigned offset", d, 32'h0);
      bus_rd(O_GAP, d);
      chk("R11 gap offset", d, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_outputs();
      t_dir();
      t_input();
      t_edge();
      t_mask();
      t_enable();
      t_level();
      t_collide();
      t_upper();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

endmodule